// File: doc/BRIEF.md
# Speculative-Safe Load Translation Unit

This block sits between a load pipeline and memory. It keeps a small fully associative table of virtual-page to physical-page mappings, written through a fill port, and resolves each load request against that table. A load whose page is present becomes a physical memory read. The returned data goes back to the register file with the request's destination tag.

Each request carries one opcode bit that marks it as either a plain load or a dismissable load. When the page is absent, a plain load raises a translation fault. A dismissable load does not fault: it finishes at once by writing an all-ones word to its destination. That word reads as a NaN in floating point and as a misaligned pointer when used as an address, so a compiler can move such loads above branches and the wrong-path ones do no harm. Memory is modelled as a read port with a fixed latency. Returns that lose the write-back port to a poison write wait in a small queue.

Top module: `dld_load_unit`

## Requirements
- R1: After reset the table holds no valid mapping, and `wb_valid`, `fault_valid` and `mem_rd_en` are all low.
- R2: A request that hits drives `mem_rd_en` with `mem_rd_paddr` = {mapped physical page, 12-bit page offset} one cycle after the request. Its data appears on the write-back port with the request tag MEM_LAT+2 cycles after the request when nothing competes.
- R3: A plain load (`req_dismiss`=0) that misses pulses `fault_valid` one cycle after the request, with the request address and tag. It issues no memory read and produces no write-back.
- R4: A dismissable load (`req_dismiss`=1) that misses writes all ones with its tag on the write-back port one cycle after the request. It raises no fault and issues no memory read.
- R5: A dismissable load that hits behaves exactly like a plain hit and writes no poison value.
- R6: A poison write takes the write-back port ahead of a pending memory return. The displaced return is held and written later, and every return is written exactly once, in arrival order.
- R7: Fills of new pages go to entries in round-robin order. Once the table is full, the ninth distinct fill replaces the first one.
- R8: A fill whose page is already present overwrites that entry's physical page in place and does not advance the replacement pointer. No page is ever held twice.
- R9: `flush` invalidates every entry in one cycle, and a fill presented in the same cycle as a flush is dropped.
- R10: A lookup in the same cycle as a fill sees the table as it was before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all mappings |
| fill_valid | input | 1 | Write a mapping |
| fill_vpn | input | VA_W-PO_W | Virtual page of the mapping |
| fill_ppn | input | PA_W-PO_W | Physical page of the mapping |
| req_valid | input | 1 | Load request present |
| req_dismiss | input | 1 | 1 = dismissable load, 0 = plain load |
| req_vaddr | input | VA_W | Load virtual address |
| req_tag | input | TAG_W | Destination register tag |
| mem_rd_en | output | 1 | Memory read issued |
| mem_rd_paddr | output | PA_W | Physical read address |
| mem_rd_data | input | DATA_W | Read data, valid MEM_LAT cycles after `mem_rd_en` |
| wb_valid | output | 1 | Register write-back |
| wb_tag | output | TAG_W | Destination tag of the write-back |
| wb_data | output | DATA_W | Write-back value (all ones for poison) |
| fault_valid | output | 1 | Translation fault request |
| fault_vaddr | output | VA_W | Faulting virtual address |
| fault_tag | output | TAG_W | Tag of the faulting load |

## Verification
The bench places a dismissable miss so that its poison write lands in the same cycle as a queued memory return. A design without proper priority would either drop the return or corrupt the poison value. It fills nine distinct pages and then refills a page that is already present: a wrong replacement pointer evicts the wrong page, and a refill that allocates instead of overwriting leaves two copies of one page or evicts a live mapping. It also presents a fill together with a lookup, and a fill together with a flush. A table that forwards the fill would turn the first poison into a hit, and one that lets the fill win would leave a stale mapping. Random traffic over a narrow page range then checks that every request ends in exactly one outcome with the right tag.

// File: rtl/dld_pkg.sv
package dld_pkg;
    typedef enum logic [1:0] {
        LD_IDLE   = 2'd0,
        LD_HIT    = 2'd1,
        LD_FAULT  = 2'd2,
        LD_POISON = 2'd3
    } ld_outcome_e;
endpackage

// File: rtl/dld_xlate_buf.sv
module dld_xlate_buf #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    typedef struct packed {
        logic [PTR_W-1:0]              ptr;
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic [ENTRIES-1:0][PPN_W-1:0] ppn;
    } xb_state_t;

    xb_state_t st_d, st_q;
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fill_match;

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
        assign lk_match[gi]   = st_q.valid[gi] && (st_q.vpn[gi] == lk_vpn);
        assign fill_match[gi] = st_q.valid[gi] && (st_q.vpn[gi] == fill_vpn);
    end

    always_comb begin
        lk_ppn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) lk_ppn = lk_ppn | st_q.ppn[i];
        end
        lk_hit = |lk_match;
    end

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.valid = '0;
        end else if (fill_valid) begin
            if (|fill_match) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (fill_match[i]) st_d.ppn[i] = fill_ppn;
                end
            end else begin
                st_d.valid[st_q.ptr] = 1'b1;
                st_d.vpn[st_q.ptr]   = fill_vpn;
                st_d.ppn[st_q.ptr]   = fill_ppn;
                st_d.ptr = (st_q.ptr == LAST) ? '0 : st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: a page is never held by two entries
    assert_single_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R8: refilling a present page keeps the pointer
    assert_refill_keeps_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush && (|fill_match)) |=> $stable(st_q.ptr));

    // R9: flush empties the table by the next cycle
    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.valid == '0));

    // R7: a fresh fill advances the replacement pointer
    assert_ptr_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush && !(|fill_match) && (ENTRIES > 1))
        |=> (st_q.ptr != $past(st_q.ptr)));
endmodule

// File: rtl/dld_ret_track.sv
module dld_ret_track #(
    parameter int LAT   = 3,
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [TAG_W-1:0] issue_tag,
    output logic             ret_valid,
    output logic [TAG_W-1:0] ret_tag
);
    typedef struct packed {
        logic [LAT-1:0]            vld;
        logic [LAT-1:0][TAG_W-1:0] tag;
    } tr_state_t;

    tr_state_t tr_d, tr_q;

    always_comb begin
        tr_d        = tr_q;
        tr_d.vld[0] = issue;
        tr_d.tag[0] = issue_tag;
        for (int i = 1; i < LAT; i++) begin
            tr_d.vld[i] = tr_q.vld[i-1];
            tr_d.tag[i] = tr_q.tag[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tr_q <= '0;
        else        tr_q <= tr_d;
    end

    assign ret_valid = tr_q.vld[LAT-1];
    assign ret_tag   = tr_q.tag[LAT-1];

    // R2: a tracked read enters the delay line
    assert_issue_tracked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> tr_q.vld[0] && (tr_q.tag[0] == $past(issue_tag)));
endmodule

// File: rtl/dld_ret_queue.sv
module dld_ret_queue #(
    parameter int DEPTH = 8,
    parameter int W     = 69
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head_data,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] slot;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } rq_state_t;

    rq_state_t rq_d, rq_q;

    always_comb begin
        rq_d = rq_q;
        if (push) begin
            rq_d.slot[rq_q.wr] = push_data;
            rq_d.wr = (rq_q.wr == LAST) ? '0 : rq_q.wr + 1'b1;
        end
        if (pop) begin
            rq_d.rd = (rq_q.rd == LAST) ? '0 : rq_q.rd + 1'b1;
        end
        case ({push, pop})
            2'b10:   rq_d.cnt = rq_q.cnt + 1'b1;
            2'b01:   rq_d.cnt = rq_q.cnt - 1'b1;
            default: rq_d.cnt = rq_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rq_q <= '0;
        else        rq_q <= rq_d;
    end

    assign head_data = rq_q.slot[rq_q.rd];
    assign empty     = (rq_q.cnt == '0);

    // R6: a held return is never overwritten
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_q.cnt == FULL) |-> !push);

    // R6: nothing is written back that was never returned
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/dld_load_unit.sv
module dld_load_unit
    import dld_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int PO_W    = 12,
    parameter int DATA_W  = 64,
    parameter int TAG_W   = 5,
    parameter int ENTRIES = 8,
    parameter int MEM_LAT = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 fill_valid,
    input  logic [VA_W-PO_W-1:0] fill_vpn,
    input  logic [PA_W-PO_W-1:0] fill_ppn,
    input  logic                 req_valid,
    input  logic                 req_dismiss,
    input  logic [VA_W-1:0]      req_vaddr,
    input  logic [TAG_W-1:0]     req_tag,
    output logic                 mem_rd_en,
    output logic [PA_W-1:0]      mem_rd_paddr,
    input  logic [DATA_W-1:0]    mem_rd_data,
    output logic                 wb_valid,
    output logic [TAG_W-1:0]     wb_tag,
    output logic [DATA_W-1:0]    wb_data,
    output logic                 fault_valid,
    output logic [VA_W-1:0]      fault_vaddr,
    output logic [TAG_W-1:0]     fault_tag
);
    localparam int VPN_W  = VA_W - PO_W;
    localparam int PPN_W  = PA_W - PO_W;
    localparam int RQ_W   = TAG_W + DATA_W;
    localparam int RQ_DEP = 2 * (MEM_LAT + 1);

    typedef struct packed {
        ld_outcome_e      kind;
        logic [VA_W-1:0]  vaddr;
        logic [PA_W-1:0]  paddr;
        logic [TAG_W-1:0] tag;
    } ld_stage_t;

    ld_stage_t s1_d, s1_q;

    logic             lk_hit;
    logic [PPN_W-1:0] lk_ppn;
    logic             ret_valid;
    logic [TAG_W-1:0] ret_tag;
    logic             q_empty;
    logic             q_pop;
    logic [RQ_W-1:0]  q_head;
    logic             poison;

    dld_xlate_buf #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) i_xlate (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .fill_valid (fill_valid),
        .fill_vpn   (fill_vpn),
        .fill_ppn   (fill_ppn),
        .lk_vpn     (req_vaddr[VA_W-1:PO_W]),
        .lk_hit     (lk_hit),
        .lk_ppn     (lk_ppn)
    );

    always_comb begin
        s1_d       = s1_q;
        s1_d.kind  = LD_IDLE;
        s1_d.vaddr = req_vaddr;
        s1_d.paddr = {lk_ppn, req_vaddr[PO_W-1:0]};
        s1_d.tag   = req_tag;
        if (req_valid) begin
            if (lk_hit)           s1_d.kind = LD_HIT;
            else if (req_dismiss) s1_d.kind = LD_POISON;
            else                  s1_d.kind = LD_FAULT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s1_q <= '0;
        else        s1_q <= s1_d;
    end

    assign mem_rd_en    = (s1_q.kind == LD_HIT);
    assign mem_rd_paddr = s1_q.paddr;
    assign fault_valid  = (s1_q.kind == LD_FAULT);
    assign fault_vaddr  = s1_q.vaddr;
    assign fault_tag    = s1_q.tag;
    assign poison       = (s1_q.kind == LD_POISON);

    dld_ret_track #(.LAT(MEM_LAT), .TAG_W(TAG_W)) i_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (mem_rd_en),
        .issue_tag (s1_q.tag),
        .ret_valid (ret_valid),
        .ret_tag   (ret_tag)
    );

    assign q_pop = !q_empty && !poison;

    dld_ret_queue #(.DEPTH(RQ_DEP), .W(RQ_W)) i_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ret_valid),
        .push_data ({ret_tag, mem_rd_data}),
        .pop       (q_pop),
        .head_data (q_head),
        .empty     (q_empty)
    );

    always_comb begin
        wb_valid = poison || !q_empty;
        if (poison) begin
            wb_tag  = s1_q.tag;
            wb_data = '1;
        end else begin
            wb_tag  = q_head[RQ_W-1:DATA_W];
            wb_data = q_head[DATA_W-1:0];
        end
    end

    // R2: a hit becomes a read of the mapped page at the same offset
    assert_hit_issues_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && lk_hit) |=>
            (mem_rd_en && (mem_rd_paddr[PO_W-1:0] == $past(req_vaddr[PO_W-1:0]))));

    // R3: a plain miss faults and reads nothing
    assert_miss_faults_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !lk_hit && !req_dismiss) |=>
            (fault_valid && !mem_rd_en && (fault_vaddr == $past(req_vaddr))));

    // R4: a dismissable miss writes all ones and does not fault
    assert_miss_poisons_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !lk_hit && req_dismiss) |=>
            (wb_valid && (wb_data == '1) && !fault_valid && !mem_rd_en));

    // R6: a return displaced by poison stays queued
    assert_poison_keeps_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (poison && !q_empty) |=> !q_empty);
endmodule

// File: tb/test_dld_load_unit.sv
`timescale 1ns/1ps
module test_dld_load_unit;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic        req_valid = 1'b0;
    logic        req_dismiss = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [4:0]  req_tag = '0;
    logic        mem_rd_en;
    logic [31:0] mem_rd_paddr;
    logic [63:0] mem_rd_data = '0;
    logic        wb_valid;
    logic [4:0]  wb_tag;
    logic [63:0] wb_data;
    logic        fault_valid;
    logic [31:0] fault_vaddr;
    logic [4:0]  fault_tag;

    always #2 clk = ~clk;

    dld_load_unit #(.MEM_LAT(LAT)) i_dld_load_unit (
        .clk(clk), .rst_n(rst_n), .flush(flush), .fill_valid(fill_valid),
        .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .req_valid(req_valid),
        .req_dismiss(req_dismiss), .req_vaddr(req_vaddr), .req_tag(req_tag),
        .mem_rd_en(mem_rd_en), .mem_rd_paddr(mem_rd_paddr), .mem_rd_data(mem_rd_data),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .fault_valid(fault_valid), .fault_vaddr(fault_vaddr), .fault_tag(fault_tag)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench translation model and expectations per tag (0 none, 1 data, 2 poison, 3 fault)
    bit          m_valid [8];
    logic [19:0] m_vpn   [8];
    logic [19:0] m_ppn   [8];
    int          m_ptr = 0;
    int          exp_kind  [32];
    logic [63:0] exp_data  [32];
    logic [31:0] exp_vaddr [32];

    logic        pv [0:LAT];
    logic [31:0] pa [0:LAT];

    function automatic logic [63:0] memval(input logic [31:0] a);
        return {a ^ 32'h5a5a0000, ~a};
    endfunction

    task automatic check(input bit ok, input string rq, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // memory: data for a read issued in cycle c is presented during cycle c+LAT
    always @(negedge clk) begin
        for (int k = LAT; k > 0; k--) begin
            pv[k] = pv[k-1];
            pa[k] = pa[k-1];
        end
        pv[0] = (rst_n === 1'b1) && (mem_rd_en === 1'b1);
        pa[0] = mem_rd_paddr;
        mem_rd_data = pv[LAT] ? memval(pa[LAT]) : 64'd0;
    end

    // outcome monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (wb_valid) begin
                if (exp_kind[wb_tag] == 2)
                    check(wb_data == '1, "R4 poison value", wb_data, '1);
                else if (exp_kind[wb_tag] == 1)
                    check(wb_data == exp_data[wb_tag], "R2 returned data", wb_data,
                          exp_data[wb_tag]);
                else
                    check(0, "R6 unexpected write-back", {59'd0, wb_tag}, 64'd0);
                exp_kind[wb_tag] = 0;
            end
            if (fault_valid) begin
                check(exp_kind[fault_tag] == 3 && fault_vaddr == exp_vaddr[fault_tag],
                      "R3 fault", {32'd0, fault_vaddr}, {32'd0, exp_vaddr[fault_tag]});
                exp_kind[fault_tag] = 0;
            end
        end
    end

    task automatic drive(input bit r, input bit d, input logic [31:0] va, input logic [4:0] t,
                         input bit f, input logic [19:0] fv, input logic [19:0] fp,
                         input bit fl);
        int hit_i;
        req_valid = r; req_dismiss = d; req_vaddr = va; req_tag = t;
        fill_valid = f; fill_vpn = fv; fill_ppn = fp; flush = fl;
        hit_i = -1;
        for (int i = 0; i < 8; i++) if (m_valid[i] && m_vpn[i] == va[31:12]) hit_i = i;
        if (r) begin
            if (exp_kind[t] != 0) check(0, "R6 tag still pending", 64'(t), 64'd0);
            exp_vaddr[t] = va;
            if (hit_i >= 0) begin
                exp_kind[t] = 1;
                exp_data[t] = memval({m_ppn[hit_i], va[11:0]});
            end else begin
                exp_kind[t] = d ? 2 : 3;
            end
        end
        if (fl) begin
            for (int i = 0; i < 8; i++) m_valid[i] = 0;
        end else if (f) begin
            hit_i = -1;
            for (int i = 0; i < 8; i++) if (m_valid[i] && m_vpn[i] == fv) hit_i = i;
            if (hit_i >= 0) m_ppn[hit_i] = fp;
            else begin
                m_valid[m_ptr] = 1; m_vpn[m_ptr] = fv; m_ppn[m_ptr] = fp;
                m_ptr = (m_ptr + 1) % 8;
            end
        end
        @(negedge clk);
        req_valid = 0; fill_valid = 0; flush = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        check(0, "watchdog", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 32; i++) exp_kind[i] = 0;
        for (int i = 0; i < 8; i++) m_valid[i] = 0;
        for (int k = 0; k <= LAT; k++) begin pv[k] = 0; pa[k] = '0; end
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: quiet outputs and empty table
        check(!wb_valid && !fault_valid && !mem_rd_en, "R1 reset outputs",
              {61'd0, wb_valid, fault_valid, mem_rd_en}, 64'd0);
        drive(1, 1, 32'h0000_5123, 5'd1, 0, 0, 0, 0);
        check(wb_valid && wb_tag == 5'd1 && wb_data == '1, "R1 empty table poisons",
              wb_data, '1);

        // R3: plain miss
        drive(1, 0, 32'h0000_7abc, 5'd2, 0, 0, 0, 0);
        check(fault_valid && fault_tag == 5'd2 && fault_vaddr == 32'h0000_7abc && !mem_rd_en,
              "R3 fault pulse", {32'd0, fault_vaddr}, 64'h7abc);

        // R10: fill alongside lookup is not seen
        drive(1, 1, 32'h0001_0abc, 5'd3, 1, 20'h00010, 20'h00333, 0);
        check(wb_valid && wb_tag == 5'd3 && wb_data == '1, "R10 lookup before fill",
              wb_data, '1);

        // R2: plain hit timing
        drive(1, 0, 32'h0001_0abc, 5'd4, 0, 0, 0, 0);
        check(mem_rd_en && mem_rd_paddr == 32'h0033_3abc && !wb_valid, "R2 read issue",
              {32'd0, mem_rd_paddr}, 64'h0033_3abc);
        idle(LAT + 1);
        check(wb_valid && wb_tag == 5'd4 && wb_data == memval(32'h0033_3abc),
              "R2 data latency", wb_data, memval(32'h0033_3abc));

        // R5: dismissable hit
        drive(1, 1, 32'h0001_0004, 5'd5, 0, 0, 0, 0);
        check(mem_rd_en && !wb_valid && !fault_valid, "R5 dismissable hit reads",
              {63'd0, wb_valid}, 64'd0);
        idle(LAT + 1);
        check(wb_valid && wb_tag == 5'd5 && wb_data == memval(32'h0033_3004),
              "R5 dismissable hit data", wb_data, memval(32'h0033_3004));

        // R6: poison collides with a queued return
        idle(2);
        drive(1, 0, 32'h0001_0100, 5'd6, 0, 0, 0, 0);
        idle(LAT);
        drive(1, 1, 32'h0009_9000, 5'd7, 0, 0, 0, 0);
        check(wb_valid && wb_tag == 5'd7 && wb_data == '1, "R6 poison wins",
              {59'd0, wb_tag}, 64'd7);
        @(negedge clk);
        check(wb_valid && wb_tag == 5'd6 && wb_data == memval(32'h0033_3100),
              "R6 displaced return kept", wb_data, memval(32'h0033_3100));

        // R7: round-robin replacement
        idle(LAT + 4);
        drive(0, 0, 0, 0, 0, 0, 0, 1);
        for (int i = 0; i < 9; i++) drive(0, 0, 0, 0, 1, 20'h00100 + 20'(i), 20'h00200 + 20'(i), 0);
        drive(1, 1, 32'h0010_0010, 5'd8, 0, 0, 0, 0);
        check(wb_valid && wb_tag == 5'd8 && wb_data == '1, "R7 oldest evicted",
              {59'd0, wb_tag}, 64'd8);
        for (int i = 1; i < 9; i++) begin
            drive(1, 1, {20'h00100 + 20'(i), 12'h020}, 5'(8 + i), 0, 0, 0, 0);
            check(mem_rd_en && mem_rd_paddr == {20'h00200 + 20'(i), 12'h020},
                  "R7 retained entry hits", {32'd0, mem_rd_paddr},
                  {32'd0, 20'h00200 + 20'(i), 12'h020});
        end

        // R8: refill in place
        idle(LAT + 6);
        drive(0, 0, 0, 0, 0, 0, 0, 1);
        for (int i = 0; i < 8; i++) drive(0, 0, 0, 0, 1, 20'h00300 + 20'(i), 20'h00500 + 20'(i), 0);
        drive(0, 0, 0, 0, 1, 20'h00301, 20'h00777, 0);
        drive(0, 0, 0, 0, 1, 20'h00308, 20'h00888, 0);
        drive(1, 1, 32'h0030_0000, 5'd20, 0, 0, 0, 0);
        check(wb_valid && wb_tag == 5'd20 && wb_data == '1, "R8 pointer not advanced",
              {59'd0, wb_tag}, 64'd20);
        drive(1, 0, 32'h0030_1abc, 5'd21, 0, 0, 0, 0);
        check(mem_rd_en && mem_rd_paddr == 32'h0077_7abc, "R8 overwritten page",
              {32'd0, mem_rd_paddr}, 64'h0077_7abc);
        drive(1, 0, 32'h0030_8000, 5'd22, 0, 0, 0, 0);
        check(mem_rd_en && mem_rd_paddr == 32'h0088_8000, "R8 new page",
              {32'd0, mem_rd_paddr}, 64'h0088_8000);

        // R9: flush with a simultaneous fill
        idle(LAT + 4);
        drive(0, 0, 0, 0, 1, 20'h00400, 20'h00123, 1);
        drive(1, 1, 32'h0040_0000, 5'd23, 0, 0, 0, 0);
        check(wb_valid && wb_tag == 5'd23 && wb_data == '1, "R9 fill dropped",
              {59'd0, wb_tag}, 64'd23);
        drive(1, 1, 32'h0030_5000, 5'd24, 0, 0, 0, 0);
        check(wb_valid && wb_tag == 5'd24 && wb_data == '1, "R9 table cleared",
              {59'd0, wb_tag}, 64'd24);

        // random traffic (R2 R3 R4 R6 R7 R8 R9)
        idle(LAT + 6);
        for (int c = 0; c < 4000; c++) begin
            bit r, d, f, fl;
            logic [31:0] va;
            r  = ($urandom % 4) != 0;
            d  = $urandom % 2;
            va = {20'($urandom % 12), 12'($urandom)};
            f  = ($urandom % 5) == 0;
            fl = ($urandom % 97) == 0;
            drive(r, d, va, 5'(c), f, 20'($urandom % 12), 20'($urandom % 4096), fl);
        end
        idle(LAT + 20);
        for (int t = 0; t < 32; t++)
            check(exp_kind[t] == 0, "R6 outcome missing", 64'(exp_kind[t]), 64'd0);
        finish_run();
    end
endmodule